// File: doc/BRIEF.md
# Interrupt Presentation Unit

This block decides, for one processor, which interrupt is shown to it. It keeps a single pending slot that holds a 24-bit source number and that source's priority. It also keeps an 8-bit current processor priority and an 8-bit inter-processor interrupt (IPI) request level. The source number and the current priority together form a 32-bit word: the priority in bits 31:24 and the source in bits 23:0. A source number of zero means the slot is empty. A numerically smaller priority is more urgent, and 0xFF is the least urgent value.

A source controller offers deliveries (source, priority). The unit either latches a delivery into its slot or sends it straight back as a reject. When a more urgent delivery or an IPI displaces the source in the slot, the displaced source is rejected back to the controller. Software acts on the unit through a one-operation-per-cycle port with four operations: set the current priority, set the IPI level, accept (read the word and take the interrupt), and end of interrupt. An end of interrupt is forwarded to the source controller. When the unit is left with nothing pending and its priority is eased or an end of interrupt arrives, it asks the controller to replay any sources it held back. A single level output tells the processor that an interrupt is pending.

Top module: `irq_present_unit`

## Requirements
- R1: After reset the word is zero (current priority 0x00, no source), the pending priority and IPI level are 0xFF, the interrupt output is low and no notice is pulsed. Because the current priority is 0x00, every delivery is rejected until software changes it.
- R2: The unit rejects a delivery on reject lane B, naming the delivered source, when either of two conditions holds. One is that its priority is not strictly below the current priority. The other is that a source is already pending with a priority less than or equal to the delivery's priority. The pending slot is then left unchanged.
- R3: The unit latches a delivery that passes R2 into the slot with its priority and drives the output high. Any source that was pending before is rejected on lane B.
- R4: Accept (op code 2) returns the whole word on acc_word with acc_vld. It then sets the current priority to the old pending priority, empties the slot, sets the pending priority to 0xFF and lowers the output.
- R5: Set-IPI (op code 1, level in op_data[7:0]) stores the level. If the level is below the current priority, an IPI check runs. The check does nothing when a pending source's priority is less than or equal to the level. Otherwise it rejects any pending source on lane A and loads source IPI_SRC (default 2) with the level as its priority, raising the output.
- R6: Set-priority (op code 0, value in op_data[7:0]) with a value below the old one stores it. If a source is pending and the new value is less than or equal to its priority, the slot is emptied, that source is rejected on lane A and the output falls. Otherwise the slot is kept.
- R7: Set-priority with a value equal to or above the old one stores it. If the slot is empty, it performs a resend: the IPI check of R5 runs when the IPI level is below the new priority, and resend_req pulses. With a source pending, no resend occurs.
- R8: End of interrupt (op code 3) loads op_data[31:24] into the current priority and pulses eoi_vld with eoi_src = op_data[23:0]. If the slot is then empty, it performs the resend of R7.
- R9: An operation and a delivery in the same cycle are applied in that order: the delivery is judged against the state the operation leaves. In particular, an accept takes effect before a simultaneous delivery.
- R10: Every result is registered. acc_word, the reject lanes, eoi and resend appear as one-cycle pulses in the cycle after the inputs are sampled, and irq_out follows the slot in that same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| op_valid | input | 1 | Register operation present this cycle |
| op_code | input | 2 | 0 set priority, 1 set IPI level, 2 accept, 3 end of interrupt |
| op_data | input | 32 | Operation operand |
| dlv_valid | input | 1 | Delivery offered by the source controller |
| dlv_src | input | 24 | Delivered source number (non-zero) |
| dlv_prio | input | 8 | Delivered priority |
| irq_out | output | 1 | Interrupt pending to the processor |
| acc_vld | output | 1 | Accept result valid |
| acc_word | output | 32 | Word returned by accept |
| rej_a_vld | output | 1 | Reject caused by a register operation |
| rej_a_src | output | 24 | Source rejected on lane A |
| rej_b_vld | output | 1 | Reject caused by a delivery |
| rej_b_src | output | 24 | Source rejected on lane B |
| eoi_vld | output | 1 | End-of-interrupt notice to the source controller |
| eoi_src | output | 24 | Source named by the end of interrupt |
| resend_req | output | 1 | Request to replay held-back sources |

## Verification
Every result of this block is due exactly one clock after the inputs that cause it. This covers the accepted word, both reject lanes, the end-of-interrupt notice, the resend pulse and the new level of irq_out. The bench drives one operation and/or delivery per cycle at the falling edge. For each cycle it queues the full expected output set, computed by hand from the requirements. The monitor compares that set just after the next rising edge. A notice that arrives a cycle early or late, or lasts more than one cycle, therefore shows up as a mismatch in a neighbouring entry.

// File: rtl/ipu_pkg.sv
package ipu_pkg;
  localparam int PRI_W  = 8;
  localparam int SRC_W  = 24;
  localparam int WORD_W = PRI_W + SRC_W;

  typedef logic [PRI_W-1:0] pri_t;
  typedef logic [SRC_W-1:0] src_t;

  typedef enum logic [1:0] {
    OP_SET_PRI = 2'd0,
    OP_SET_IPI = 2'd1,
    OP_ACCEPT  = 2'd2,
    OP_EOI     = 2'd3
  } ipu_op_e;

  typedef struct packed {
    pri_t cur_pri;
    src_t pend_src;
    pri_t pend_pri;
    pri_t ipi_lvl;
  } ipu_state_t;

  localparam pri_t PRI_NONE = '1;
endpackage

// File: rtl/ipu_op_stage.sv
module ipu_op_stage
  import ipu_pkg::*;
#(
  parameter src_t IPI_SRC = 24'd2
) (
  input  ipu_state_t          cur,
  input  logic                op_valid,
  input  logic [1:0]          op_code,
  input  logic [WORD_W-1:0]   op_data,
  output ipu_state_t          nxt,
  output logic                rej_vld,
  output src_t                rej_src,
  output logic                eoi_vld,
  output src_t                eoi_src,
  output logic                resend,
  output logic                acc_vld,
  output logic [WORD_W-1:0]   acc_word
);
  localparam int PRI_LSB = SRC_W;

  ipu_state_t st;
  logic       want_resend;
  logic       want_ipi;
  pri_t       arg_pri;

  assign arg_pri = op_data[PRI_W-1:0];

  always_comb begin
    st          = cur;
    rej_vld     = 1'b0;
    rej_src     = '0;
    eoi_vld     = 1'b0;
    eoi_src     = '0;
    resend      = 1'b0;
    acc_vld     = 1'b0;
    acc_word    = '0;
    want_resend = 1'b0;
    want_ipi    = 1'b0;

    if (op_valid) begin
      unique case (ipu_op_e'(op_code))
        OP_SET_PRI: begin
          st.cur_pri = arg_pri;
          if (arg_pri < cur.cur_pri) begin
            if ((cur.pend_src != '0) && (arg_pri <= cur.pend_pri)) begin
              rej_vld     = 1'b1;
              rej_src     = cur.pend_src;
              st.pend_src = '0;
              st.pend_pri = PRI_NONE;
            end
          end else if (cur.pend_src == '0) begin
            want_resend = 1'b1;
          end
        end
        OP_SET_IPI: begin
          st.ipi_lvl = arg_pri;
          if (arg_pri < cur.cur_pri) want_ipi = 1'b1;
        end
        OP_ACCEPT: begin
          acc_vld     = 1'b1;
          acc_word    = {cur.cur_pri, cur.pend_src};
          st.cur_pri  = cur.pend_pri;
          st.pend_src = '0;
          st.pend_pri = PRI_NONE;
        end
        OP_EOI: begin
          st.cur_pri = op_data[WORD_W-1:PRI_LSB];
          eoi_vld    = 1'b1;
          eoi_src    = op_data[SRC_W-1:0];
          if (cur.pend_src == '0) want_resend = 1'b1;
        end
        default: ;
      endcase
    end

    // resend: IPI check first, then replay request
    if (want_resend) begin
      resend = 1'b1;
      if (st.ipi_lvl < st.cur_pri) want_ipi = 1'b1;
    end

    if (want_ipi) begin
      if (!((st.pend_src != '0) && (st.pend_pri <= st.ipi_lvl))) begin
        if (st.pend_src != '0) begin
          rej_vld = 1'b1;
          rej_src = st.pend_src;
        end
        st.pend_src = IPI_SRC;
        st.pend_pri = st.ipi_lvl;
      end
    end

    nxt = st;
  end
endmodule

// File: rtl/ipu_dlv_stage.sv
module ipu_dlv_stage
  import ipu_pkg::*;
(
  input  ipu_state_t cur,
  input  logic       dlv_valid,
  input  src_t       dlv_src,
  input  pri_t       dlv_prio,
  output ipu_state_t nxt,
  output logic       rej_vld,
  output src_t       rej_src
);
  logic occupied;
  logic refuse;

  assign occupied = (cur.pend_src != '0);
  assign refuse   = (dlv_prio >= cur.cur_pri) ||
                    (occupied && (cur.pend_pri <= dlv_prio));

  always_comb begin
    nxt     = cur;
    rej_vld = 1'b0;
    rej_src = '0;
    if (dlv_valid) begin
      if (refuse) begin
        rej_vld = 1'b1;
        rej_src = dlv_src;
      end else begin
        if (occupied) begin
          rej_vld = 1'b1;
          rej_src = cur.pend_src;
        end
        nxt.pend_src = dlv_src;
        nxt.pend_pri = dlv_prio;
      end
    end
  end
endmodule

// File: rtl/irq_present_unit.sv
module irq_present_unit
  import ipu_pkg::*;
#(
  parameter src_t IPI_SRC   = 24'd2,
  parameter int   SYNC_LEN  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              op_valid,
  input  logic [1:0]        op_code,
  input  logic [31:0]       op_data,
  input  logic              dlv_valid,
  input  logic [23:0]       dlv_src,
  input  logic [7:0]        dlv_prio,
  output logic              irq_out,
  output logic              acc_vld,
  output logic [31:0]       acc_word,
  output logic              rej_a_vld,
  output logic [23:0]       rej_a_src,
  output logic              rej_b_vld,
  output logic [23:0]       rej_b_src,
  output logic              eoi_vld,
  output logic [23:0]       eoi_src,
  output logic              resend_req
);
  localparam ipu_state_t RST_STATE = '{cur_pri: '0, pend_src: '0,
                                       pend_pri: PRI_NONE, ipi_lvl: PRI_NONE};

  // reset: asserted asynchronously, released on the clock
  logic [SYNC_LEN-1:0] rst_pipe;
  logic                rst_s_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[SYNC_LEN-2:0], 1'b1};
  end
  assign rst_s_n = rst_pipe[SYNC_LEN-1];

  ipu_state_t state_q;
  ipu_state_t mid_st;
  ipu_state_t end_st;

  logic        op_rej_vld;
  src_t        op_rej_src;
  logic        op_eoi_vld;
  src_t        op_eoi_src;
  logic        op_resend;
  logic        op_acc_vld;
  logic [31:0] op_acc_word;
  logic        dv_rej_vld;
  src_t        dv_rej_src;
  logic        state_en;

  ipu_op_stage #(.IPI_SRC(IPI_SRC)) u_op (
    .cur      (state_q),
    .op_valid (op_valid),
    .op_code  (op_code),
    .op_data  (op_data),
    .nxt      (mid_st),
    .rej_vld  (op_rej_vld),
    .rej_src  (op_rej_src),
    .eoi_vld  (op_eoi_vld),
    .eoi_src  (op_eoi_src),
    .resend   (op_resend),
    .acc_vld  (op_acc_vld),
    .acc_word (op_acc_word)
  );

  ipu_dlv_stage u_dlv (
    .cur       (mid_st),
    .dlv_valid (dlv_valid),
    .dlv_src   (dlv_src),
    .dlv_prio  (dlv_prio),
    .nxt       (end_st),
    .rej_vld   (dv_rej_vld),
    .rej_src   (dv_rej_src)
  );

  assign state_en = op_valid | dlv_valid;

  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n) begin
      state_q <= RST_STATE;
    end else if (state_en) begin
      state_q <= end_st;
    end
  end

  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n) begin
      irq_out    <= 1'b0;
      acc_vld    <= 1'b0;
      acc_word   <= '0;
      rej_a_vld  <= 1'b0;
      rej_a_src  <= '0;
      rej_b_vld  <= 1'b0;
      rej_b_src  <= '0;
      eoi_vld    <= 1'b0;
      eoi_src    <= '0;
      resend_req <= 1'b0;
    end else begin
      if (state_en) irq_out <= (end_st.pend_src != '0);
      acc_vld    <= op_acc_vld;
      acc_word   <= op_acc_word;
      rej_a_vld  <= op_rej_vld;
      rej_a_src  <= op_rej_src;
      rej_b_vld  <= dv_rej_vld;
      rej_b_src  <= dv_rej_src;
      eoi_vld    <= op_eoi_vld;
      eoi_src    <= op_eoi_src;
      resend_req <= op_resend;
    end
  end
endmodule

// File: rtl/irq_present_unit_sva.sv
module ipu_checker
  import ipu_pkg::*;
(
  input logic        clk,
  input logic        rst_n,
  input ipu_state_t  state_q,
  input logic        op_valid,
  input logic [1:0]  op_code,
  input logic [31:0] op_data,
  input logic        dlv_valid,
  input logic [23:0] dlv_src,
  input logic [7:0]  dlv_prio,
  input logic        irq_out,
  input logic        acc_vld,
  input logic        rej_b_vld,
  input logic [23:0] rej_b_src,
  input logic        eoi_vld,
  input logic [23:0] eoi_src
);
  // R10: output level mirrors slot occupancy
  p_irq_level_r10: assert property (@(posedge clk) disable iff (!rst_n)
    irq_out == (state_q.pend_src != '0));

  // R4: empty slot always carries the none priority
  p_empty_none_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q.pend_src == '0) |-> (state_q.pend_pri == PRI_NONE));

  // R2: delivery not below current priority is refused
  p_refuse_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!op_valid && dlv_valid && (dlv_prio >= state_q.cur_pri))
    |=> (rej_b_vld && (rej_b_src == $past(dlv_src))));

  // R4: lone accept returns a word and drops the line
  p_accept_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && (op_code == 2'd2) && !dlv_valid)
    |=> (acc_vld && !irq_out && (state_q.pend_pri == PRI_NONE)));

  // R8: end of interrupt forwards the source and loads the priority
  p_eoi_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && (op_code == 2'd3))
    |=> (eoi_vld && (eoi_src == $past(op_data[23:0]))
         && (state_q.cur_pri == $past(op_data[31:24]))));

  // R5: IPI level is stored
  p_ipi_store_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && (op_code == 2'd1))
    |=> (state_q.ipi_lvl == $past(op_data[7:0])));

  // R6: set-priority value is stored
  p_pri_store_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && (op_code == 2'd0))
    |=> (state_q.cur_pri == $past(op_data[7:0])));
endmodule

bind irq_present_unit ipu_checker u_ipu_checker (
  .clk       (clk),
  .rst_n     (rst_s_n),
  .state_q   (state_q),
  .op_valid  (op_valid),
  .op_code   (op_code),
  .op_data   (op_data),
  .dlv_valid (dlv_valid),
  .dlv_src   (dlv_src),
  .dlv_prio  (dlv_prio),
  .irq_out   (irq_out),
  .acc_vld   (acc_vld),
  .rej_b_vld (rej_b_vld),
  .rej_b_src (rej_b_src),
  .eoi_vld   (eoi_vld),
  .eoi_src   (eoi_src)
);

// File: tb/irq_present_unit_tb.sv
module irq_present_unit_tb_top;
  localparam int VW = 110;

  logic        clk;
  logic        rst_n;
  logic        op_valid;
  logic [1:0]  op_code;
  logic [31:0] op_data;
  logic        dlv_valid;
  logic [23:0] dlv_src;
  logic [7:0]  dlv_prio;
  logic        irq_out, acc_vld, rej_a_vld, rej_b_vld, eoi_vld, resend_req;
  logic [31:0] acc_word;
  logic [23:0] rej_a_src, rej_b_src, eoi_src;

  irq_present_unit dut_i (
    .clk(clk), .rst_n(rst_n),
    .op_valid(op_valid), .op_code(op_code), .op_data(op_data),
    .dlv_valid(dlv_valid), .dlv_src(dlv_src), .dlv_prio(dlv_prio),
    .irq_out(irq_out), .acc_vld(acc_vld), .acc_word(acc_word),
    .rej_a_vld(rej_a_vld), .rej_a_src(rej_a_src),
    .rej_b_vld(rej_b_vld), .rej_b_src(rej_b_src),
    .eoi_vld(eoi_vld), .eoi_src(eoi_src), .resend_req(resend_req)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  typedef struct {
    string        tag;
    logic [VW-1:0] v;
  } exp_t;

  exp_t exp_q[$];
  int   total = 0;
  int   bad   = 0;
  int   cyc   = 0;
  bit   done  = 0;

  function automatic logic [VW-1:0] ex(bit irq, bit av, logic [31:0] aw,
      bit rav, logic [23:0] ras, bit rbv, logic [23:0] rbs,
      bit ev, logic [23:0] es, bit rs);
    return {irq, av, aw, rav, ras, rbv, rbs, ev, es, rs};
  endfunction

  localparam logic [VW-1:0] IDLE0 = '0;
  localparam logic [VW-1:0] IDLE1 = {1'b1, 109'b0};

  // monitor: compares one queued item per rising edge
  always @(posedge clk) begin
    #1;
    if (exp_q.size() > 0) begin
      exp_t e;
      logic [VW-1:0] act;
      e   = exp_q.pop_front();
      act = {irq_out, acc_vld, acc_word, rej_a_vld, rej_a_src, rej_b_vld,
             rej_b_src, eoi_vld, eoi_src, resend_req};
      total++;
      if (act !== e.v) begin
        bad++;
        $display("FAIL %s act=%h exp=%h", e.tag, act, e.v);
      end
    end
  end

  task automatic step(string tag, bit ov, logic [1:0] oc, logic [31:0] od,
                      bit dv, logic [23:0] ds, logic [7:0] dp,
                      logic [VW-1:0] e);
    exp_t it;
    @(negedge clk);
    op_valid = ov; op_code = oc; op_data = od;
    dlv_valid = dv; dlv_src = ds; dlv_prio = dp;
    it.tag = tag; it.v = e;
    exp_q.push_back(it);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 5000) begin
      total++; bad++;
      $display("FAIL watchdog act=%0d exp=<5000", cyc);
      finish_run();
    end
  end

  initial begin
    rst_n = 1'b0;
    op_valid = 0; op_code = 0; op_data = 0;
    dlv_valid = 0; dlv_src = 0; dlv_prio = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1 reset state: nothing pulsed, line low
    step("R1 idle after reset", 0, 0, 0, 0, 0, 0, IDLE0);
    // R1: priority 0 refuses everything
    step("R1 refuse at prio 0", 0, 0, 0, 1, 24'h10, 8'h05,
         ex(0,0,0, 0,0, 1,24'h10, 0,0, 0));
    // R1/R4: accept returns zero word, current becomes FF
    step("R1 accept reset word", 1, 2, 0, 0, 0, 0,
         ex(0,1,32'h0, 0,0, 0,0, 0,0, 0));
    step("R3 latch first", 0, 0, 0, 1, 24'h10, 8'h05, IDLE1);
    step("R2 tie refused", 0, 0, 0, 1, 24'h11, 8'h05,
         ex(1,0,0, 0,0, 1,24'h11, 0,0, 0));
    step("R3 displace", 0, 0, 0, 1, 24'h12, 8'h03,
         ex(1,0,0, 0,0, 1,24'h10, 0,0, 0));
    step("R2 FF refused", 0, 0, 0, 1, 24'h13, 8'hFF,
         ex(1,0,0, 0,0, 1,24'h13, 0,0, 0));
    step("R4 accept", 1, 2, 0, 0, 0, 0,
         ex(0,1,32'hFF000012, 0,0, 0,0, 0,0, 0));
    step("R2 equal to current refused", 0, 0, 0, 1, 24'h14, 8'h03,
         ex(0,0,0, 0,0, 1,24'h14, 0,0, 0));
    step("R3 latch below current", 0, 0, 0, 1, 24'h14, 8'h02, IDLE1);
    step("R5 ipi not below current", 1, 1, 32'h04, 0, 0, 0, IDLE1);
    step("R5 ipi blocked by pending", 1, 1, 32'h02, 0, 0, 0, IDLE1);
    step("R5 ipi displaces", 1, 1, 32'h01, 0, 0, 0,
         ex(1,0,0, 1,24'h14, 0,0, 0,0, 0));
    step("R4 accept ipi", 1, 2, 0, 0, 0, 0,
         ex(0,1,32'h03000002, 0,0, 0,0, 0,0, 0));
    step("R8 eoi resend reloads ipi", 1, 3, 32'h05000002, 0, 0, 0,
         ex(1,0,0, 0,0, 0,0, 1,24'h2, 1));
    step("R6 lower prio clears", 1, 0, 32'h01, 0, 0, 0,
         ex(0,0,0, 1,24'h2, 0,0, 0,0, 0));
    step("R5 ipi none", 1, 1, 32'hFF, 0, 0, 0, IDLE0);
    step("R7 raise prio resend", 1, 0, 32'h06, 0, 0, 0,
         ex(0,0,0, 0,0, 0,0, 0,0, 1));
    step("R3 latch 20", 0, 0, 0, 1, 24'h20, 8'h04, IDLE1);
    step("R6 lower prio keeps better", 1, 0, 32'h05, 0, 0, 0, IDLE1);
    step("R7 raise with pending no resend", 1, 0, 32'h07, 0, 0, 0, IDLE1);
    step("R9 accept then latch", 1, 2, 0, 1, 24'h21, 8'h03,
         ex(1,1,32'h07000020, 0,0, 0,0, 0,0, 0));
    step("R9 accept then refuse", 1, 2, 0, 1, 24'h22, 8'h04,
         ex(0,1,32'h04000021, 0,0, 1,24'h22, 0,0, 0));
    step("R8 eoi empty resend plus latch", 1, 3, 32'h0A000021, 1, 24'h23, 8'h09,
         ex(1,0,0, 0,0, 0,0, 1,24'h21, 1));
    step("R8 eoi with pending no resend", 1, 3, 32'hFF000023, 0, 0, 0,
         ex(1,0,0, 0,0, 0,0, 1,24'h23, 0));
    step("R10 pulses end", 0, 0, 0, 0, 0, 0, IDLE1);
    step("R6 both lanes", 1, 0, 32'h00, 1, 24'h30, 8'h01,
         ex(0,0,0, 1,24'h23, 1,24'h30, 0,0, 0));
    step("R10 idle after", 0, 0, 0, 0, 0, 0, IDLE0);

    @(negedge clk);
    op_valid = 0; dlv_valid = 0;
    wait (exp_q.size() == 0);
    @(negedge clk);
    finish_run();
  end
endmodule